// File: doc/BRIEF.md
# Multi-Channel PWM Control Register and Interrupt Bank

This block holds the software-visible state of an eight-channel pulse-width modulator. It decodes a simple bus with a write strobe, a read strobe, a byte address and a data word, and it exports per-channel control fields and divider settings to counters that sit outside it. Each channel has a control word and a divider word in its own group of registers. The groups repeat at a fixed stride. Above the groups sits a global run register that reaches the same physical run flops as the per-channel control words. One write to it can start or stop any set of channels in the same clock edge, so those channels stay in step.

The block also holds the interrupt state. Each channel counter reports a one-cycle wrap pulse, and that pulse latches a pending bit. Software clears a pending bit by writing 1 to it. A mask register selects which pending bits reach the output. A separate override register asserts status bits whatever the pending and mask bits are. A single interrupt line is the OR of all status bits. Reads are combinational: read data is valid in the same cycle as the read strobe and is zero when the strobe is low.

Top module: `pwm_regbank`

## Requirements
- R1: After reset every register reads zero, `ch_en` is zero and `irq` is low.
- R2: Channel n's control word is at byte address n*0x14. Bit 0 is run, bit 1 is centre-aligned mode, bit 2 inverts output A, bit 3 inverts output B, and bits 5:4 are the clock mode (0 free, 1 gated, 2 rising edge, 3 falling edge). Each field reads back and drives its output port one cycle after the write.
- R3: Channel n's divider word is at byte address n*0x14+4. Bits 3:0 are the fractional part and bits 11:4 the integer part. Both read back and drive `ch_div_frac` and `ch_div_int`.
- R4: Writing one channel's group leaves every other channel's control and divider words unchanged.
- R5: The global run register at 0xa0 maps bit n to channel n's run flop. One write updates all channels' `ch_en` bits on the same edge, and the new value shows in bit 0 of each control word.
- R6: Writing bit 0 of a control word changes that channel's bit in the global run register. `ch_en` changes only on a write.
- R7: The pending register at 0xa4 sets bit n on a wrap pulse of channel n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: A wrap pulse in the same cycle as a clearing write to the same bit leaves that bit set.
- R9: The mask register at 0xa8 and the override register at 0xac are read/write, with bit n belonging to channel n.
- R10: The status register at 0xb0 reads (pending AND mask) OR override for each bit. Writes to it have no effect.
- R11: `irq` is high exactly when some status bit is 1.
- R12: Bits above the defined fields read zero and ignore writes. Addresses that match no register, including addresses that are not word-aligned, read zero and a write to them changes nothing.
- R13: `rdata` is zero while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW (8) | Byte address |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data, same cycle as `rd_en` |
| wrap_evt | input | NCH (8) | One-cycle wrap pulses from the channel counters |
| ch_en | output | NCH | Run enable for each channel |
| ch_center | output | NCH | Centre-aligned mode for each channel |
| ch_inv_a | output | NCH | Invert output A for each channel |
| ch_inv_b | output | NCH | Invert output B for each channel |
| ch_mode | output | 2*NCH | Clock mode, two bits per channel |
| ch_div_int | output | NCH*INT_W | Integer part of each channel's divider |
| ch_div_frac | output | NCH*FRAC_W | Fractional part of each channel's divider |
| irq | output | 1 | Combined interrupt |

## Verification
A run flop that drifts from the global register shows up in `ch_en` on the edge after the write. Reading the global register or the control word exposes it on the next read. A pending bit that is wrong shows in the status read and on `irq` in the cycle after the wrap or the clear, provided its mask bit is set. The bench therefore sets masks and overrides deliberately, so that a masked-out bit cannot hide a fault. A decode error in the group stride shows as a wrong value when another channel's words are read back. The bench writes every channel before it reads any of them back.

// File: rtl/pwm_regbank_pkg.sv
package pwm_regbank_pkg;

   localparam int unsigned GRP_STRIDE     = 'h14;
   localparam int unsigned CTRL_OFS       = 'h00;
   localparam int unsigned DIV_OFS        = 'h04;
   localparam int unsigned GLB_RUN_ADDR   = 'ha0;
   localparam int unsigned IRQ_PEND_ADDR  = 'ha4;
   localparam int unsigned IRQ_MASK_ADDR  = 'ha8;
   localparam int unsigned IRQ_OVR_ADDR   = 'hac;
   localparam int unsigned IRQ_STAT_ADDR  = 'hb0;

   localparam int unsigned CTL_W = 6;

   typedef enum logic [1:0] {
      CLK_FREE  = 2'd0,
      CLK_GATED = 2'd1,
      CLK_RISE  = 2'd2,
      CLK_FALL  = 2'd3
   } clk_mode_e;

   // bits 5:1 of the control word, run flop kept separately in bit 0
   typedef struct packed {
      clk_mode_e mode;
      logic      inv_b;
      logic      inv_a;
      logic      center;
   } ctl_fields_t;

   function automatic int unsigned grp_base(input int unsigned n);
      return n * GRP_STRIDE;
   endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
   import pwm_regbank_pkg::*;
#(
   parameter int unsigned DW     = 32,
   parameter int unsigned INT_W  = 8,
   parameter int unsigned FRAC_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ctl_we,
   input  logic                    div_we,
   input  logic                    glb_we,
   input  logic                    glb_run,
   input  logic [CTL_W-1:0]        ctl_wdata,
   input  logic [INT_W+FRAC_W-1:0] div_wdata,
   output logic                    run,
   output ctl_fields_t             fields,
   output logic [INT_W-1:0]        div_int,
   output logic [FRAC_W-1:0]       div_frac,
   output logic [DW-1:0]           ctl_rd,
   output logic [DW-1:0]           div_rd
);

   // the single run flop: reached from the control word and the global register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
      end else if (ctl_we) begin
         run <= ctl_wdata[0];
      end else if (glb_we) begin
         run <= glb_run;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fields <= '0;
      end else if (ctl_we) begin
         fields <= ctl_fields_t'(ctl_wdata[CTL_W-1:1]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_int  <= '0;
         div_frac <= '0;
      end else if (div_we) begin
         div_int  <= div_wdata[INT_W+FRAC_W-1:FRAC_W];
         div_frac <= div_wdata[FRAC_W-1:0];
      end
   end

   assign ctl_rd = DW'({fields, run});
   assign div_rd = DW'({div_int, div_frac});

endmodule

// File: rtl/pwm_irq_regs.sv
module pwm_irq_regs #(
   parameter int unsigned NCH         = 8,
   parameter bit          IRQ_REG_OUT = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pend_we,
   input  logic           mask_we,
   input  logic           ovr_we,
   input  logic [NCH-1:0] wdata,
   input  logic [NCH-1:0] wrap,
   output logic [NCH-1:0] pend,
   output logic [NCH-1:0] mask,
   output logic [NCH-1:0] ovr,
   output logic [NCH-1:0] status,
   output logic           irq
);

   logic [NCH-1:0] clr;

   assign clr = pend_we ? wdata : '0;

   // a wrap in the same cycle as a clear keeps the bit set
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
      end else begin
         pend <= (pend & ~clr) | wrap;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= '0;
         ovr  <= '0;
      end else begin
         if (mask_we) mask <= wdata;
         if (ovr_we)  ovr  <= wdata;
      end
   end

   assign status = (pend & mask) | ovr;

   generate
      if (IRQ_REG_OUT) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |status;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |status;
      end
   endgenerate

endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
   import pwm_regbank_pkg::*;
#(
   parameter int unsigned NCH         = 8,
   parameter int unsigned DW          = 32,
   parameter int unsigned AW          = 8,
   parameter int unsigned INT_W       = 8,
   parameter int unsigned FRAC_W      = 4,
   parameter bit          IRQ_REG_OUT = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [AW-1:0]           addr,
   input  logic [DW-1:0]           wdata,
   output logic [DW-1:0]           rdata,
   input  logic [NCH-1:0]          wrap_evt,
   output logic [NCH-1:0]          ch_en,
   output logic [NCH-1:0]          ch_center,
   output logic [NCH-1:0]          ch_inv_a,
   output logic [NCH-1:0]          ch_inv_b,
   output logic [2*NCH-1:0]        ch_mode,
   output logic [NCH*INT_W-1:0]    ch_div_int,
   output logic [NCH*FRAC_W-1:0]   ch_div_frac,
   output logic                    irq
);

   localparam int unsigned DIV_W   = INT_W + FRAC_W;
   localparam int unsigned USED_W0 = (CTL_W > DIV_W) ? CTL_W : DIV_W;
   localparam int unsigned USED_W  = (USED_W0 > NCH) ? USED_W0 : NCH;
   localparam int unsigned GRP_END = NCH * GRP_STRIDE;

   localparam logic [AW-1:0] A_GLB  = AW'(GLB_RUN_ADDR);
   localparam logic [AW-1:0] A_PEND = AW'(IRQ_PEND_ADDR);
   localparam logic [AW-1:0] A_MASK = AW'(IRQ_MASK_ADDR);
   localparam logic [AW-1:0] A_OVR  = AW'(IRQ_OVR_ADDR);
   localparam logic [AW-1:0] A_STAT = AW'(IRQ_STAT_ADDR);

   // elaboration-time parameter checks
   generate
      if (NCH < 1 || NCH > DW) begin : g_bad_nch
         $fatal(1, "pwm_regbank: NCH must be in 1..DW");
      end
      if (GRP_END > GLB_RUN_ADDR) begin : g_bad_map
         $fatal(1, "pwm_regbank: channel groups overlap the global registers");
      end
      if ((1 << AW) <= IRQ_STAT_ADDR) begin : g_bad_aw
         $fatal(1, "pwm_regbank: AW too small for the register map");
      end
      if (USED_W > DW) begin : g_bad_dw
         $fatal(1, "pwm_regbank: fields do not fit in DW");
      end
      if (USED_W < DW) begin : g_hi_bits
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^wdata[DW-1:USED_W];
      end
   endgenerate

   logic [NCH-1:0] ctl_we;
   logic [NCH-1:0] div_we;
   logic           glb_we;
   logic [DW-1:0]  ctl_rd [NCH];
   logic [DW-1:0]  div_rd [NCH];
   logic [NCH-1:0] irq_pend;
   logic [NCH-1:0] irq_mask;
   logic [NCH-1:0] irq_ovr;
   logic [NCH-1:0] irq_stat;

   assign glb_we = wr_en && (addr == A_GLB);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         localparam logic [AW-1:0] A_CTL = AW'(grp_base(i) + CTRL_OFS);
         localparam logic [AW-1:0] A_DIV = AW'(grp_base(i) + DIV_OFS);
         ctl_fields_t f;

         assign ctl_we[i] = wr_en && (addr == A_CTL);
         assign div_we[i] = wr_en && (addr == A_DIV);

         pwm_chan_regs #(
            .DW     (DW),
            .INT_W  (INT_W),
            .FRAC_W (FRAC_W)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (ctl_we[i]),
            .div_we    (div_we[i]),
            .glb_we    (glb_we),
            .glb_run   (wdata[i]),
            .ctl_wdata (wdata[CTL_W-1:0]),
            .div_wdata (wdata[DIV_W-1:0]),
            .run       (ch_en[i]),
            .fields    (f),
            .div_int   (ch_div_int[i*INT_W +: INT_W]),
            .div_frac  (ch_div_frac[i*FRAC_W +: FRAC_W]),
            .ctl_rd    (ctl_rd[i]),
            .div_rd    (div_rd[i])
         );

         assign ch_center[i]    = f.center;
         assign ch_inv_a[i]     = f.inv_a;
         assign ch_inv_b[i]     = f.inv_b;
         assign ch_mode[2*i +: 2] = f.mode;
      end
   endgenerate

   pwm_irq_regs #(
      .NCH         (NCH),
      .IRQ_REG_OUT (IRQ_REG_OUT)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_we (wr_en && (addr == A_PEND)),
      .mask_we (wr_en && (addr == A_MASK)),
      .ovr_we  (wr_en && (addr == A_OVR)),
      .wdata   (wdata[NCH-1:0]),
      .wrap    (wrap_evt),
      .pend    (irq_pend),
      .mask    (irq_mask),
      .ovr     (irq_ovr),
      .status  (irq_stat),
      .irq     (irq)
   );

   // combinational read mux; unmatched addresses fall through to zero
   always_comb begin
      rdata = '0;
      if (rd_en) begin
         for (int i = 0; i < NCH; i++) begin
            if (addr == AW'(grp_base(i) + CTRL_OFS)) rdata = ctl_rd[i];
            if (addr == AW'(grp_base(i) + DIV_OFS))  rdata = div_rd[i];
         end
         if (addr == A_GLB)  rdata = DW'(ch_en);
         if (addr == A_PEND) rdata = DW'(irq_pend);
         if (addr == A_MASK) rdata = DW'(irq_mask);
         if (addr == A_OVR)  rdata = DW'(irq_ovr);
         if (addr == A_STAT) rdata = DW'(irq_stat);
      end
   end

endmodule

// File: rtl/pwm_regbank_chk.sv
module pwm_regbank_chk
   import pwm_regbank_pkg::*;
#(
   parameter int unsigned NCH         = 8,
   parameter int unsigned DW          = 32,
   parameter int unsigned AW          = 8,
   parameter bit          IRQ_REG_OUT = 1'b0
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_en,
   input logic           rd_en,
   input logic [AW-1:0]  addr,
   input logic [DW-1:0]  wdata,
   input logic [DW-1:0]  rdata,
   input logic [NCH-1:0] wrap_evt,
   input logic [NCH-1:0] ch_en,
   input logic [NCH-1:0] pend,
   input logic [NCH-1:0] ovr,
   input logic           irq
);

   localparam logic [AW-1:0] A_GLB  = AW'(GLB_RUN_ADDR);
   localparam logic [AW-1:0] A_PEND = AW'(IRQ_PEND_ADDR);
   localparam logic [AW-1:0] A_STAT = AW'(IRQ_STAT_ADDR);

   assert_glb_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_GLB) |=> (ch_en == $past(wdata[NCH-1:0])));

   assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ch_en));

   assert_wrap_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_evt != '0) |=> ((pend & $past(wrap_evt)) == $past(wrap_evt)));

   assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_PEND) |=> ((pend & $past(wdata[NCH-1:0] & ~wrap_evt)) == '0));

   assert_ovr_raises_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG_OUT && ovr != '0) |-> irq);

   assert_stat_matches_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG_OUT && rd_en && addr == A_STAT) |-> (irq == (rdata[NCH-1:0] != '0)));

   assert_idle_rdata_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));

endmodule

bind pwm_regbank pwm_regbank_chk #(
   .NCH         (NCH),
   .DW          (DW),
   .AW          (AW),
   .IRQ_REG_OUT (IRQ_REG_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .wrap_evt (wrap_evt),
   .ch_en    (ch_en),
   .pend     (irq_pend),
   .ovr      (irq_ovr),
   .irq      (irq)
);

// File: tb/tb_pwm_regbank.sv
`timescale 1ns/1ps
module tb_pwm_regbank;

   localparam int NCH = 8;
   localparam int DW  = 32;
   localparam int AW  = 8;
   localparam int IW  = 8;
   localparam int FW  = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            wr_en, rd_en;
   logic [AW-1:0]   addr;
   logic [DW-1:0]   wdata;
   logic [DW-1:0]   rdata;
   logic [NCH-1:0]  wrap_evt;
   logic [NCH-1:0]  ch_en, ch_center, ch_inv_a, ch_inv_b;
   logic [2*NCH-1:0] ch_mode;
   logic [NCH*IW-1:0] ch_div_int;
   logic [NCH*FW-1:0] ch_div_frac;
   logic            irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   always #2 clk = ~clk;

   pwm_regbank dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .wrap_evt(wrap_evt), .ch_en(ch_en),
      .ch_center(ch_center), .ch_inv_a(ch_inv_a), .ch_inv_b(ch_inv_b),
      .ch_mode(ch_mode), .ch_div_int(ch_div_int), .ch_div_frac(ch_div_frac),
      .irq(irq)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected read value away from the active edge
   always @(negedge clk) begin
      if (rst_n && rd_en) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R13 unexpected read actual %h expected none", rdata);
         end else begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, rdata, e);
         end
      end
   end

   task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NCH-1:0] w = '0);
      wr_en = 1'b1; addr = a; wdata = d; wrap_evt = w;
      @(posedge clk); #1;
      wr_en = 1'b0; wrap_evt = '0; wdata = '0;
   endtask

   task automatic do_wrap(input logic [NCH-1:0] w);
      wrap_evt = w;
      @(posedge clk); #1;
      wrap_evt = '0;
   endtask

   task automatic do_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      rd_en = 1'b1; addr = a;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual running expected finished");
         summary();
         $finish;
      end
   end

   logic [DW-1:0] dv [NCH];

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; wrap_evt = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1 ch_en", DW'(ch_en), 0);
      chk("R1 irq", DW'(irq), 0);
      for (int i = 0; i < NCH; i++) begin
         do_rd(AW'(i*20), 0, "R1 ctrl");
         do_rd(AW'(i*20+4), 0, "R1 div");
      end
      for (int a = 'ha0; a <= 'hb0; a += 4) do_rd(AW'(a), 0, "R1 global");

      // R2 / R12 control fields, reserved bits
      do_wr(8'd60, 32'hFFFF_FFFF);
      chk("R2 mode ch3", DW'(ch_mode[7:6]), 3);
      chk("R2 center ch3", DW'(ch_center), 32'h08);
      chk("R2 inv_a ch3", DW'(ch_inv_a), 32'h08);
      chk("R2 inv_b ch3", DW'(ch_inv_b), 32'h08);
      chk("R5 run ch3 via ctrl", DW'(ch_en), 32'h08);
      do_rd(8'd60, 32'h3F, "R2 R12 ctrl ch3 readback");
      do_rd(8'ha0, 32'h08, "R5 global shows ch3");
      do_wr(8'd100, 32'h0000_0026);
      chk("R2 mode ch5", DW'(ch_mode[11:10]), 2);
      chk("R2 center", DW'(ch_center), 32'h28);
      chk("R2 inv_a", DW'(ch_inv_a), 32'h28);
      chk("R2 inv_b", DW'(ch_inv_b), 32'h08);
      do_rd(8'd100, 32'h26, "R2 ctrl ch5 readback");

      // R3 / R4 dividers on every channel, then read back all
      for (int i = 0; i < NCH; i++) begin
         dv[i] = 32'hFFF0_0000 | ((i * 32'h153 + 32'h3) & 32'hFFF);
         do_wr(AW'(i*20+4), dv[i]);
         chk("R3 div_int", DW'(ch_div_int[i*IW +: IW]), DW'(dv[i][11:4]));
         chk("R3 div_frac", DW'(ch_div_frac[i*FW +: FW]), DW'(dv[i][3:0]));
      end
      for (int i = 0; i < NCH; i++) do_rd(AW'(i*20+4), dv[i] & 32'hFFF, "R4 R12 div stride readback");
      do_rd(8'd60, 32'h3F, "R4 ctrl ch3 untouched");

      // R5 global run write
      do_wr(8'ha0, 32'hFFFF_FF5A);
      chk("R5 ch_en", DW'(ch_en), 32'h5A);
      do_rd(8'ha0, 32'h5A, "R5 R12 global readback");
      do_rd(8'd20, 32'h01, "R5 ctrl ch1 run bit");
      do_rd(8'd60, 32'h3F, "R5 ctrl ch3 run bit");
      do_rd(8'd100, 32'h26, "R5 ctrl ch5 run bit");
      do_rd(8'd120, 32'h01, "R5 ctrl ch6 run bit");

      // R13 idle read strobe
      addr = 8'ha0; #1;
      chk("R13 rdata idle", rdata, 0);

      // R6 control word bit 0 feeds the global register
      do_wr(8'd60, 32'h0000_0030);
      chk("R6 ch_en after ctrl clear", DW'(ch_en), 32'h52);
      do_rd(8'ha0, 32'h52, "R6 global after ctrl clear");
      do_wr(8'd0, 32'h0000_0001);
      do_rd(8'ha0, 32'h53, "R6 global after ctrl set");
      repeat (3) @(posedge clk);
      #1 chk("R6 ch_en holds", DW'(ch_en), 32'h53);

      // R7 pending set and write-1-to-clear
      do_wrap(8'h0F);
      do_rd(8'ha4, 32'h0F, "R7 pending after wraps");
      chk("R11 irq masked", DW'(irq), 0);
      do_wr(8'ha4, 32'h0000_0003);
      do_rd(8'ha4, 32'h0C, "R7 w1c");
      do_wr(8'ha4, 32'h0000_0000);
      do_rd(8'ha4, 32'h0C, "R7 write zero keeps");

      // R8 set beats clear
      do_wr(8'ha4, 32'h0000_003C, 8'h30);
      do_rd(8'ha4, 32'h30, "R8 wrap wins over clear");

      // R9 / R10 / R11
      do_wr(8'ha8, 32'hFFFF_FF10);
      do_rd(8'ha8, 32'h10, "R9 mask readback");
      do_rd(8'hb0, 32'h10, "R10 status masked");
      chk("R11 irq from masked pending", DW'(irq), 1);
      do_wr(8'hac, 32'h0000_0080);
      do_rd(8'hac, 32'h80, "R9 override readback");
      do_rd(8'hb0, 32'h90, "R10 status with override");
      do_wr(8'ha8, 32'h0);
      do_wr(8'ha4, 32'hFF);
      do_rd(8'ha4, 32'h00, "R7 clear all");
      do_rd(8'hb0, 32'h80, "R10 override only");
      chk("R11 irq from override", DW'(irq), 1);
      do_wr(8'hb0, 32'hFF);
      do_rd(8'hb0, 32'h80, "R10 status write ignored");
      do_wr(8'hac, 32'h0);
      chk("R11 irq low", DW'(irq), 0);
      do_rd(8'hb0, 32'h00, "R10 status zero");
      do_wr(8'ha8, 32'hFF);
      chk("R11 irq low with mask only", DW'(irq), 0);
      do_wrap(8'h01);
      chk("R11 irq after wrap", DW'(irq), 1);

      // R12 unmapped and unaligned
      do_wr(8'h08, 32'hFFFF_FFFF);
      do_wr(8'ha1, 32'hFFFF_FFFF);
      chk("R12 ch_en unchanged", DW'(ch_en), 32'h53);
      do_rd(8'h08, 32'h0, "R12 unmapped in group");
      do_rd(8'ha1, 32'h0, "R12 unaligned");
      do_rd(8'hb4, 32'h0, "R12 above map");
      do_rd(8'h94, 32'h0, "R12 last group gap");
      do_rd(8'hac, 32'h0, "R12 override untouched");

      @(posedge clk); #1;
      chk("R13 scoreboard drained", DW'(exp_q.size()), 0);
      done = 1;
      summary();
      $finish;
   end

endmodule